// File: doc/BRIEF.md
# Dual-Latch Parity Bus Transceiver

A symmetric bridge between two 9-bit buses, A and B. Each bus word holds eight data bits in positions 7:0 and a parity bit in position 8. Each side has its own latch. The latch passes its bus input straight through while its enable is high, and it keeps the value captured at the last clock edge while the enable is low. The contents of the A latch go to the B bus, and the contents of the B latch go to the A bus.

The outgoing parity bit is chosen by one select input for both directions. It is either freshly computed from the eight source data bits or taken unchanged from the received parity bit. A second input picks even or odd parity, and that choice applies to both generation and checking. Both latches are checked all the time, and each drives its own active-low error flag. This checking continues while neither bus is driven, so a bus can be monitored passively.

Each tri-state bus is split into separate in, out and output-enable ports. A request to drive both buses at once is refused: both enables are forced off and a sticky flag is set, which only reset clears.

Top module: `parity_xcvr`

## Requirements
- R1: With `a_le` high, `b_out[7:0]` equals `a_in[7:0]` in the same cycle. The same holds for `a_out[7:0]` and `b_in[7:0]` with `b_le` high.
- R2: While `a_le` (or `b_le`) is low, the latch keeps the word captured at the last rising clock edge at which its enable was high. Changes on the bus input do not reach the opposite output or the error flag.
- R3: With `par_pass` low, output bit 8 is the XOR of the eight source data bits, inverted when `odd_sel` is 1. The source data are the latched contents when the latch is closed.
- R4: With `par_pass` high, output bit 8 equals bit 8 of the source latch contents, whatever the data bits are.
- R5: `a_err_n` (or `b_err_n`) is 0 exactly when the 9 bits of that latch hold an odd count of ones with `odd_sel`=0, or an even count with `odd_sel`=1. This holds whatever the output-enable inputs are.
- R6: The B-to-A direction behaves exactly like A-to-B, with the roles of the two sides swapped.
- R7: `b_oe` is 1 only when `drv_b_n`=0 and `drv_a_n`=1. `a_oe` is 1 only when `drv_a_n`=0 and `drv_b_n`=1. With both inputs at 1, neither bus is driven.
- R8: With `drv_a_n`=0 and `drv_b_n`=0, both enables are 0. `illegal` rises at the next clock edge and stays 1 until reset.
- R9: While `rst_n` is low, both enables are 0, both error flags are 1 and `illegal` is 0. Reset clears both latches to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latches capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 9 | A bus value seen at the pins (bit 8 parity) |
| a_out | output | 9 | Value driven onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | 9 | B bus value seen at the pins (bit 8 parity) |
| b_out | output | 9 | Value driven onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |
| a_le | input | 1 | A latch enable, transparent when high |
| b_le | input | 1 | B latch enable, transparent when high |
| drv_a_n | input | 1 | Active-low request to drive the A bus |
| drv_b_n | input | 1 | Active-low request to drive the B bus |
| par_pass | input | 1 | 1 = received parity passed through, 0 = parity generated |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_err_n | output | 1 | Active-low parity error on the A latch |
| b_err_n | output | 1 | Active-low parity error on the B latch |
| illegal | output | 1 | Sticky flag: both buses were requested at once |

## Verification
Every combination of the drive requests, parity mode, parity sense and the two latch enables is applied with data words of different ones-counts. This separates generated parity from passed-through parity and even parity from odd. Words with a deliberately wrong parity bit, and words with one flipped data bit, are fed to both latches while neither bus is driven; they show whether each error flag follows its own latch alone. Closing a latch and then changing its bus input shows that the outputs, the generated parity and the error flag come from the held word and not from the live pins. Requesting both buses, then returning to a legal setting, shows the refusal and the sticky flag.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] a_in,
  output logic [WW-1:0] a_out,
  output logic          a_oe,
  input  logic [WW-1:0] b_in,
  output logic [WW-1:0] b_out,
  output logic          b_oe,
  input  logic          a_le,
  input  logic          b_le,
  input  logic          drv_a_n,
  input  logic          drv_b_n,
  input  logic          par_pass,
  input  logic          odd_sel,
  output logic          a_err_n,
  output logic          b_err_n,
  output logic          illegal
);

  logic [WW-1:0] a_q, b_q;
  logic [WW-1:0] a_view, b_view;
  logic          a_gen, b_gen;
  logic          illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_le) a_q <= a_in;
      if (b_le) b_q <= b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   illegal_q <= 1'b0;
    else if (!drv_a_n && !drv_b_n) illegal_q <= 1'b1;
  end

  assign a_view = a_le ? a_in : a_q;
  assign b_view = b_le ? b_in : b_q;

  assign a_gen = ^a_view[DW-1:0] ^ odd_sel;
  assign b_gen = ^b_view[DW-1:0] ^ odd_sel;

  assign b_out = {par_pass ? a_view[DW] : a_gen, a_view[DW-1:0]};
  assign a_out = {par_pass ? b_view[DW] : b_gen, b_view[DW-1:0]};

  assign b_oe = rst_n && !drv_b_n && drv_a_n;
  assign a_oe = rst_n && !drv_a_n && drv_b_n;

  assign a_err_n = !rst_n || !(^a_view ^ odd_sel);
  assign b_err_n = !rst_n || !(^b_view ^ odd_sel);

  assign illegal = illegal_q;

  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_le |=> $stable(a_q));
  assert_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b_le |=> $stable(b_q));
  assert_pass_par_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_pass |-> (b_out[DW] == a_view[DW] && a_out[DW] == b_view[DW]));
  assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));
  assert_clash_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_a_n && !drv_b_n) |=> illegal);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  always @(posedge clk)
    if (!rst_n)
      assert_reset_quiet_R9: assert (!a_oe && !b_oe && a_err_n && b_err_n && !illegal);

endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [8:0] a_in = 0, b_in = 0;
  logic       a_le = 0, b_le = 0, drv_a_n = 1, drv_b_n = 1, par_pass = 0, odd_sel = 0;
  logic [8:0] a_out, b_out;
  logic       a_oe, b_oe, a_err_n, b_err_n, illegal;

  always #5 clk = ~clk;

  parity_xcvr uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .a_le(a_le), .b_le(b_le),
    .drv_a_n(drv_a_n), .drv_b_n(drv_b_n), .par_pass(par_pass), .odd_sel(odd_sel),
    .a_err_n(a_err_n), .b_err_n(b_err_n), .illegal(illegal)
  );

  typedef struct {
    int         req;
    logic [8:0] a_out, b_out;
    logic       a_oe, b_oe, a_err_n, b_err_n, illegal;
  } item_t;

  item_t      sbq[$];
  int         n_run = 0, n_fail = 0;
  logic [8:0] ma = 0, mb = 0;
  logic       mill = 0;

  function automatic logic bad(input logic [8:0] w, input logic odd);
    return (^w) != odd;
  endfunction

  task automatic step_model();
    if (!rst_n) begin ma = 0; mb = 0; mill = 0; end
    else begin
      if (a_le) ma = a_in;
      if (b_le) mb = b_in;
      if (!drv_a_n && !drv_b_n) mill = 1;
    end
  endtask

  task automatic apply(input logic dan, dbn, pas, odd, ale, ble,
                       input logic [8:0] ain, bin, input int req);
    item_t it;
    logic [8:0] av, bv;
    @(posedge clk);
    step_model();
    #1;
    drv_a_n = dan; drv_b_n = dbn; par_pass = pas; odd_sel = odd;
    a_le = ale; b_le = ble; a_in = ain; b_in = bin;
    av = ale ? ain : ma;
    bv = ble ? bin : mb;
    it.req     = req;
    it.b_out   = {pas ? av[8] : ((^av[7:0]) ^ odd), av[7:0]};
    it.a_out   = {pas ? bv[8] : ((^bv[7:0]) ^ odd), bv[7:0]};
    it.b_oe    = rst_n && !dbn && dan;
    it.a_oe    = rst_n && !dan && dbn;
    it.a_err_n = !rst_n || !bad(av, odd);
    it.b_err_n = !rst_n || !bad(bv, odd);
    it.illegal = mill;
    sbq.push_back(it);
  endtask

  task automatic chk(input int req, input string what, input logic [8:0] act, exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      n_run++;
      chk(e.req, "a_oe", {8'd0, a_oe}, {8'd0, e.a_oe});
      chk(e.req, "b_oe", {8'd0, b_oe}, {8'd0, e.b_oe});
      chk(e.req, "a_err_n", {8'd0, a_err_n}, {8'd0, e.a_err_n});
      chk(e.req, "b_err_n", {8'd0, b_err_n}, {8'd0, e.b_err_n});
      chk(e.req, "illegal", {8'd0, illegal}, {8'd0, e.illegal});
      if (e.b_oe) chk(e.req, "b_out", b_out, e.b_out);
      if (e.a_oe) chk(e.req, "a_out", a_out, e.a_out);
    end
  end

  task automatic finish_run();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9: quiet outputs during reset
    apply(0, 1, 0, 0, 1, 1, 9'h1FF, 9'h101, 9);
    apply(1, 0, 1, 1, 1, 1, 9'h0F0, 9'h003, 9);
    @(posedge clk); #1 rst_n = 1; a_le = 0; b_le = 0;
    // R9: latches cleared, seen with latches closed
    apply(1, 0, 0, 0, 0, 0, 9'h1AB, 9'h1CD, 9);
    apply(0, 1, 0, 1, 0, 0, 9'h1AB, 9'h1CD, 9);
    // R1 R3 R7: flow-through with generated parity, A to B
    for (int k = 0; k < 8; k++)
      apply(1, 0, 0, k[0], 1, 0, {1'b0, 8'(k * 37 + 1)}, 9'h000, 1);
    // R6: B to A direction
    for (int k = 0; k < 8; k++)
      apply(0, 1, 0, k[1], 0, 1, 9'h000, {k[0], 8'(k * 53 + 7)}, 6);
    // R2 R3: close A latch, live input changes must not show
    apply(1, 0, 0, 0, 1, 0, 9'h0A5, 9'h000, 2);
    apply(1, 0, 0, 0, 0, 0, 9'h1FF, 9'h000, 2);
    apply(1, 0, 0, 1, 0, 0, 9'h013, 9'h000, 3);
    // R2 R6: close B latch
    apply(0, 1, 0, 0, 0, 1, 9'h000, 9'h107, 2);
    apply(0, 1, 0, 0, 0, 0, 9'h000, 9'h0F0, 6);
    // R4: parity passed through even when wrong
    apply(1, 0, 1, 0, 1, 0, 9'h101, 9'h000, 4);
    apply(1, 0, 1, 1, 1, 0, 9'h0FF, 9'h000, 4);
    apply(0, 1, 1, 0, 0, 1, 9'h000, 9'h1C3, 4);
    // R5: single-bit errors with both buses idle
    for (int k = 0; k < 9; k++) begin
      apply(1, 1, 0, 0, 1, 1, 9'h000 ^ (9'h1 << k), 9'h0C0, 5);
      apply(1, 1, 0, 1, 1, 1, 9'h103, 9'h001 ^ (9'h1 << k), 5);
    end
    // R1 R3 R4 R5 R6 R7: sweep every control combination
    for (int m = 0; m < 48; m++) begin
      logic dan, dbn;
      dan = (m / 16 == 1);
      dbn = (m / 16 != 1);
      if (m / 16 == 2) begin dan = 1; dbn = 1; end
      apply(dan, dbn, m[3], m[2], m[1], m[0], {m[0], 8'(m * 29 + 3)}, {m[2], 8'(m * 71 + 5)}, 7);
      apply(dan, dbn, m[3], m[2], m[1], m[0], {~m[1], 8'(m * 13)}, {m[3], 8'(m * 91 + 1)}, 5);
    end
    // R8: both requested, then back to legal; flag stays
    apply(0, 0, 0, 0, 1, 1, 9'h055, 9'h0AA, 8);
    apply(1, 0, 0, 0, 1, 1, 9'h055, 9'h0AA, 8);
    apply(1, 1, 0, 0, 1, 1, 9'h055, 9'h0AA, 8);
    apply(0, 1, 1, 1, 0, 0, 9'h055, 9'h0AA, 8);
    // R9: reset clears the flag
    @(posedge clk); #1 rst_n = 0;
    apply(1, 0, 0, 0, 0, 0, 9'h000, 9'h000, 9);
    @(posedge clk); #1 rst_n = 1;
    apply(1, 0, 0, 0, 0, 0, 9'h000, 9'h000, 9);
    finish_run();
  end
endmodule